// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous user port and an external asynchronous byte-wide static RAM with 128K locations. The user side takes one read or one write at a time: a 17-bit address, a write flag and an 8-bit write byte, accepted with a valid/ready handshake. A read returns its byte on `rd_data` together with a single-cycle `rd_valid` strobe.

On the memory side the controller drives a select pair made of one active-low enable and one active-high enable. It also drives an active-low write strobe, an active-low output enable and the address. The data bus is split into an outgoing byte, an incoming byte and a drive-enable, which the pad ring uses to build the tristate. Every memory pin comes from a flop.

The phase lengths are set in system-clock cycles by parameters: read cycle time `TRC_CYC`, address access time `TAA_CYC`, write pulse `TWP_CYC` and data setup `TDS_CYC`. Writes are strobed by the write enable, with both chip enables held active for the whole write. The output enable stays inactive during a write, which allows the shorter write pulse that the memory permits in that case. The bus drive-enable is never asserted in a cycle that touches one in which the memory output is enabled.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ready`=1, `mem_sel_n`=1, `mem_sel`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `rd_valid`=0.
- R2: `ready` is 1 only while the controller is idle. A request is taken when `req_valid` and `ready` are both 1 at a clock edge. A `req_valid` raised while `ready` is 0 has no effect, so the addressed byte is left unwritten.
- R3: A read holds the device selected (`mem_sel_n`=0, `mem_sel`=1), `mem_we_n`=1 and `mem_oe_n`=0 on the request's address for exactly `TAA_CYC` cycles, starting in the cycle after acceptance.
- R4: `rd_valid` is 1 for exactly one cycle, `TAA_CYC`+1 cycles after the accepting edge. During that cycle `rd_data` holds the byte present on `mem_dq_in` in the last access cycle.
- R5: A write keeps `mem_oe_n`=1 throughout. It holds `mem_we_n`=0 for max(`TWP_CYC`,`TDS_CYC`) cycles, and during each of those cycles `mem_dq_oe`=1 and `mem_dq_out` equals the request's byte.
- R6: `mem_dq_oe` never rises unless `mem_oe_n` was 1 in the previous cycle. `mem_oe_n` is never 0 in the cycle after one with `mem_dq_oe`=1.
- R7: During a write both enables stay active for 1 + pulse + recovery cycles, where recovery is max(1, `TRC_CYC`−1−pulse). The address is stable in all of those cycles.
- R8: From the accepting edge, `ready` returns after 1 + pulse + recovery cycles for a write. For a read it returns after `TAA_CYC` + max(1, `TRC_CYC`−`TAA_CYC`) cycles.
- R9: Whenever `ready`=1, and in the read cycles after the access phase, both enables are inactive (`mem_sel_n`=1, `mem_sel`=0), `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R10: A request held valid across a busy period is accepted at the first edge where `ready` is 1. The new operation's pins change in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request byte address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Controller idle, request can be taken |
| rd_valid | output | 1 | One-cycle strobe for returned read byte |
| rd_data | output | 8 | Returned read byte |
| mem_addr | output | 17 | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive-enable |
| mem_dq_in | input | 8 | Byte sampled from the data bus |

## Verification
Two events can fall on the same edge: the end of a write's recovery phase and the acceptance of a read that has been waiting with `req_valid` held high. That edge is also where the data bus turns around from controller-driven to memory-driven. The bench starts a write and then, without dropping `req_valid`, changes the request to a read of the same address. It checks that the read is taken on the first `ready` cycle and that the output enable falls in the following cycle. It also checks that the drive-enable and the output enable never touch in adjacent cycles, and that the returned byte equals the one just written. A bench memory model returns a poison byte until `TAA_CYC` access cycles have passed, so a capture one cycle early is seen as a data mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE       = 3'd0,
    PH_RD_ACCESS  = 3'd1,
    PH_RD_CAPTURE = 3'd2,
    PH_WR_SETUP   = 3'd3,
    PH_WR_PULSE   = 3'd4,
    PH_WR_RECOVER = 3'd5
  } phase_e;

  typedef struct packed {
    logic sel;
    logic wr;
    logic rd;
    logic drive;
  } pin_ctl_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // write strobe must cover both the pulse width and the data setup window
  function automatic int wr_pulse_cycles(input int twp, input int tds);
    return max_of(max_of(twp, tds), 1);
  endfunction

  // pad the write so that setup + pulse + recovery reaches the cycle time
  function automatic int wr_recover_cycles(input int trc, input int twp, input int tds);
    return max_of(1, trc - 1 - wr_pulse_cycles(twp, tds));
  endfunction

  function automatic int rd_access_cycles(input int taa);
    return max_of(taa, 1);
  endfunction

  function automatic int rd_capture_cycles(input int trc, input int taa);
    return max_of(1, trc - rd_access_cycles(taa));
  endfunction

  function automatic int longest_phase(input int trc, input int taa,
                                       input int twp, input int tds);
    return max_of(max_of(wr_pulse_cycles(twp, tds), wr_recover_cycles(trc, twp, tds)),
                  max_of(rd_access_cycles(taa), rd_capture_cycles(trc, taa)));
  endfunction

  // pin intent for each phase; polarity is applied at the pin register
  function automatic pin_ctl_t pins_for(input phase_e ph);
    pin_ctl_t c;
    c = '0;
    case (ph)
      PH_WR_SETUP, PH_WR_RECOVER: c.sel = 1'b1;
      PH_WR_PULSE: begin
        c.sel   = 1'b1;
        c.wr    = 1'b1;
        c.drive = 1'b1;
      end
      PH_RD_ACCESS: begin
        c.sel = 1'b1;
        c.rd  = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int ACC_LEN  = 5,
  parameter int CAP_LEN  = 1,
  parameter int PUL_LEN  = 3,
  parameter int REC_LEN  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output phase_e           phase_nxt,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture,
  output logic             ready
);

  localparam logic [CNT_W-1:0] SETUP_V = '0;
  localparam logic [CNT_W-1:0] ACC_V   = CNT_W'(ACC_LEN - 1);
  localparam logic [CNT_W-1:0] CAP_V   = CNT_W'(CAP_LEN - 1);
  localparam logic [CNT_W-1:0] PUL_V   = CNT_W'(PUL_LEN - 1);
  localparam logic [CNT_W-1:0] REC_V   = CNT_W'(REC_LEN - 1);

  phase_e phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end

  always_comb begin
    phase_nxt = phase;
    load      = 1'b0;
    load_val  = '0;
    case (phase)
      PH_IDLE: begin
        if (req_valid) begin
          load = 1'b1;
          if (req_write) begin
            phase_nxt = PH_WR_SETUP;
            load_val  = SETUP_V;
          end else begin
            phase_nxt = PH_RD_ACCESS;
            load_val  = ACC_V;
          end
        end
      end
      PH_WR_SETUP: begin
        if (expired) begin
          phase_nxt = PH_WR_PULSE;
          load      = 1'b1;
          load_val  = PUL_V;
        end
      end
      PH_WR_PULSE: begin
        if (expired) begin
          phase_nxt = PH_WR_RECOVER;
          load      = 1'b1;
          load_val  = REC_V;
        end
      end
      PH_WR_RECOVER: begin
        if (expired) phase_nxt = PH_IDLE;
      end
      PH_RD_ACCESS: begin
        if (expired) begin
          phase_nxt = PH_RD_CAPTURE;
          load      = 1'b1;
          load_val  = CAP_V;
        end
      end
      PH_RD_CAPTURE: begin
        if (expired) phase_nxt = PH_IDLE;
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  assign ready   = (phase == PH_IDLE);
  assign accept  = ready && req_valid;
  assign capture = (phase == PH_RD_ACCESS) && expired;

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_nxt,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  pin_ctl_t ctl_nxt;
  assign ctl_nxt = pins_for(phase_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_sel_n <= 1'b1;
      mem_sel   <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_sel_n <= ~ctl_nxt.sel;
      mem_sel   <= ctl_nxt.sel;
      mem_we_n  <= ~ctl_nxt.wr;
      mem_oe_n  <= ~ctl_nxt.rd;
      mem_dq_oe <= ctl_nxt.drive;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int TRC_CYC = 5,
  parameter int TAA_CYC = 5,
  parameter int TWP_CYC = 3,
  parameter int TDS_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int ACC_LEN = rd_access_cycles(TAA_CYC);
  localparam int CAP_LEN = rd_capture_cycles(TRC_CYC, TAA_CYC);
  localparam int PUL_LEN = wr_pulse_cycles(TWP_CYC, TDS_CYC);
  localparam int REC_LEN = wr_recover_cycles(TRC_CYC, TWP_CYC, TDS_CYC);
  localparam int LONGEST = longest_phase(TRC_CYC, TAA_CYC, TWP_CYC, TDS_CYC);
  localparam int CNT_W   = $clog2(LONGEST + 1);

  // named internal events, observed by the bound checker
  phase_e           phase_nxt;
  logic             accept;
  logic             capture;
  logic             expired;
  logic             load;
  logic [CNT_W-1:0] load_val;

  sram_seq #(
    .CNT_W   (CNT_W),
    .ACC_LEN (ACC_LEN),
    .CAP_LEN (CAP_LEN),
    .PUL_LEN (PUL_LEN),
    .REC_LEN (REC_LEN)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .expired   (expired),
    .phase_nxt (phase_nxt),
    .load      (load),
    .load_val  (load_val),
    .accept    (accept),
    .capture   (capture),
    .ready     (ready)
  );

  sram_phase_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  sram_pin_drv #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_nxt  (phase_nxt),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  sram_rd_capture #(
    .DATA_W (DATA_W)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .mem_dq_in (mem_dq_in),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic              accept,
  input logic              capture
);

  AST_DRIVE_AFTER_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (mem_oe_n && $past(mem_oe_n))); // R6

  AST_OE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !$past(mem_dq_oe)); // R6

  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe)); // R5

  AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_sel_n && mem_sel)); // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && !$past(mem_sel_n)) |-> $stable(mem_addr)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe)); // R9

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready); // R2

  AST_CAPTURE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> rd_valid); // R4

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R4

  AST_STROBE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!mem_oe_n) && mem_oe_n)); // R3

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sram_ctrl_test.sv
`timescale 1ns/1ps
module sram_ctrl_test;

  localparam int A_W = 17;
  localparam int D_W = 8;
  localparam int TRC = 5;
  localparam int TAA = 5;
  localparam int TWP = 3;
  localparam int TDS = 2;

  // expected phase lengths, restated from the requirements
  localparam int E_PULSE   = (TWP > TDS) ? TWP : TDS;
  localparam int E_REC     = (TRC - 1 - E_PULSE > 1) ? (TRC - 1 - E_PULSE) : 1;
  localparam int E_CAP     = (TRC - TAA > 1) ? (TRC - TAA) : 1;
  localparam int E_WR_BUSY = 1 + E_PULSE + E_REC;
  localparam int E_RD_BUSY = TAA + E_CAP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [A_W-1:0] req_addr = '0;
  logic [D_W-1:0] req_wdata = '0;
  logic ready, rd_valid;
  logic [D_W-1:0] rd_data;
  logic [A_W-1:0] mem_addr;
  logic mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [D_W-1:0] mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sram_ctrl #(
    .ADDR_W(A_W), .DATA_W(D_W), .TRC_CYC(TRC), .TAA_CYC(TAA),
    .TWP_CYC(TWP), .TDS_CYC(TDS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // memory model: poison byte until the access time has elapsed
  logic [D_W-1:0] mem [64];
  int acc;
  wire selected = !mem_sel_n && mem_sel;
  wire reading  = selected && mem_we_n && !mem_oe_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'(i) ^ 8'h3C;
      acc <= 0;
    end else begin
      acc <= reading ? acc + 1 : 0;
      if (selected && !mem_we_n && mem_dq_oe) mem[mem_addr[5:0]] <= mem_dq_out;
    end
  end

  assign mem_dq_in = (reading && acc >= TAA - 1) ? mem[mem_addr[5:0]] : 8'hEE;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bus turnaround monitor (R6)
  logic prev_oe_n = 1'b1;
  logic prev_dq_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (mem_dq_oe || !mem_oe_n)) begin
      chk(!(mem_dq_oe && !mem_oe_n) && !(mem_dq_oe && !prev_oe_n) &&
          !(!mem_oe_n && prev_dq_oe), "R6 turnaround",
          {prev_dq_oe, prev_oe_n, mem_dq_oe, mem_oe_n}, 0);
    end
    prev_oe_n  = mem_oe_n;
    prev_dq_oe = mem_dq_oe;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic reset_check();
    @(negedge clk);
    chk({ready, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid} == 7'b1101100,
        "R1 reset pins", {ready, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid},
        7'b1101100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1 R9 first cycle idle", {ready, mem_sel_n, mem_sel}, 3'b110);
  endtask

  task automatic do_write(input logic [A_W-1:0] a, input logic [D_W-1:0] d,
                          input bit poke, input logic [A_W-1:0] pa);
    int we_cnt = 0, oe_cnt = 0, sel_cnt = 0, bad = 0, bad_addr = 0, rdy_at = 0;
    chk(ready, "R2 ready before write", ready, 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == 1) req_valid = 1'b0;
      if (poke && i == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = pa; req_wdata = 8'h77;
      end
      if (poke && i == 3) req_valid = 1'b0;
      if (ready) begin rdy_at = i; break; end
      if (selected) sel_cnt++;
      if (selected && mem_addr !== a) bad_addr++;
      if (!mem_oe_n) oe_cnt++;
      if (!mem_we_n) begin
        we_cnt++;
        if (!mem_dq_oe || mem_dq_out !== d) bad++;
      end
    end
    req_valid = 1'b0;
    chk(we_cnt == E_PULSE, "R5 write pulse length", we_cnt, E_PULSE);
    chk(oe_cnt == 0, "R5 output enable held high", oe_cnt, 0);
    chk(bad == 0, "R5 data driven during pulse", bad, 0);
    chk(sel_cnt == E_WR_BUSY, "R7 enables across write", sel_cnt, E_WR_BUSY);
    chk(bad_addr == 0, "R7 address stable", bad_addr, 0);
    chk(rdy_at == E_WR_BUSY + 1, "R8 write cycle time", rdy_at, E_WR_BUSY + 1);
  endtask

  task automatic do_read(input logic [A_W-1:0] a, input logic [D_W-1:0] exp);
    int oe_cnt = 0, sel_cnt = 0, bad_addr = 0, v_cnt = 0, v_at = 0, rdy_at = 0;
    logic [D_W-1:0] got = '0;
    chk(ready, "R2 ready before read", ready, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == 1) req_valid = 1'b0;
      if (rd_valid) begin v_cnt++; v_at = i; got = rd_data; end
      if (ready) begin rdy_at = i; break; end
      if (selected) sel_cnt++;
      if (reading) oe_cnt++;
      if (selected && mem_addr !== a) bad_addr++;
    end
    chk(oe_cnt == TAA, "R3 access phase length", oe_cnt, TAA);
    chk(bad_addr == 0, "R3 read address", bad_addr, 0);
    chk(sel_cnt == TAA, "R9 deselected after access", sel_cnt, TAA);
    chk(v_cnt == 1 && v_at == TAA + 1, "R4 strobe timing", v_at, TAA + 1);
    chk(got == exp, "R4 read data", got, exp);
    chk(rdy_at == E_RD_BUSY + 1, "R8 read cycle time", rdy_at, E_RD_BUSY + 1);
  endtask

  // write then a read held pending across the busy period
  task automatic back_to_back(input logic [A_W-1:0] a, input logic [D_W-1:0] d);
    int rdy_at = 0, v_at = 0;
    logic [D_W-1:0] got = '0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == 1) req_write = 1'b0;
      if (ready) begin rdy_at = i; break; end
    end
    chk(rdy_at == E_WR_BUSY + 1, "R10 pending read waits for write", rdy_at, E_WR_BUSY + 1);
    @(negedge clk);
    chk(!ready && !mem_oe_n && selected, "R10 read starts next cycle",
        {ready, mem_oe_n, selected}, 3'b001);
    req_valid = 1'b0;
    for (int j = 2; j <= 40; j++) begin
      @(negedge clk);
      if (rd_valid) begin v_at = j; got = rd_data; break; end
    end
    chk(v_at == TAA + 1, "R10 R4 strobe after pending read", v_at, TAA + 1);
    chk(got == d, "R10 read back after turnaround", got, d);
    while (!ready) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_check();
    do_read(17'h00005, 8'h05 ^ 8'h3C);
    do_write(17'h00001, 8'h00, 1'b0, '0);
    do_write(17'h00002, 8'hFF, 1'b0, '0);
    do_write(17'h00003, 8'hA5, 1'b1, 17'h00004);
    do_write(17'h10007, 8'hC3, 1'b0, '0);
    do_read(17'h00001, 8'h00);
    do_read(17'h00002, 8'hFF);
    do_read(17'h00003, 8'hA5);
    do_read(17'h00004, 8'h04 ^ 8'h3C); // R2 request raised while busy was ignored
    do_read(17'h10007, 8'hC3);
    back_to_back(17'h00009, 8'h5A);
    do_read(17'h00009, 8'h5A);
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule